// File: doc/BRIEF.md
# Cascadable Dual 16-Bit Counter Pair

This block holds two 16-bit counter channels, a low channel and a high channel. Each can run on its own, or the two can be joined into one 32-bit counter. The low channel counts either one of four prescaler tick inputs or a two-phase quadrature signal. The high channel counts its own selected tick, its own quadrature pair, or the carry and borrow events of the low channel. The carry and borrow path is selected by one reserved clock-select code.

Software sets up the block through a narrow write port. That port carries a configuration word per channel (run bit, quadrature-mode bit, clock-select field) and a direct load of either count. Both counts can be read back separately. A registered 32-bit snapshot presents both halves as they stood on the same clock edge.

Top module: `cascade_ctr_pair`

## Requirements
- R1: After reset both counts, both configuration words and the 32-bit snapshot are zero.
- R2: In normal mode (quad bit 0), a running channel whose clock-select code is 0 to 3 adds 1 on each cycle in which `tick_i[code]` is high, wrapping 0xFFFF to 0x0000. Codes 4 to 6 never count. On the low channel, code 7 is reserved and never counts. Every change is a step of at most one.
- R3: When the high channel is in normal mode with code 7, a low-count step from 0xFFFF to 0x0000 adds 1 to the high count on the same clock edge.
- R4: When the high channel is in normal mode with code 7, a low-count step from 0x0000 to 0xFFFF subtracts 1 from the high count on the same edge. That borrow can only arise while the low channel is in quadrature mode. In normal mode the low channel never borrows.
- R5: In quadrature mode a channel counts every single-bit change of its {A,B} pair. The up sequence (A leading B) is 00, 10, 11, 01, 00; the reverse order counts down. A change of both bits at once counts nothing. The count reflects a change after the third rising clock edge that follows it.
- R6: A high channel in quadrature mode counts only its own quadrature pair. Its clock-select field, the ticks and the low channel's carries and borrows have no effect on it.
- R7: A channel whose run bit is 0 holds its count. It ignores ticks, quadrature changes and cascade events.
- R8: A count load takes the written value on the next edge and overrides any counting in that cycle. Loading the low count never produces a carry or borrow into the high channel.
- R9: `cnt_cat_o` equals {high count, low count} as they stood one edge earlier.
- R10: Write addresses: 0 is the low configuration, 1 the high configuration, 2 the low count, 3 the high count. Configuration bit 4 is run, bit 3 is quad mode and bits 2:0 are clock select. Higher data bits of a configuration write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| tick_i | input | 4 | Prescaler tick pulses, one-cycle enables |
| quad_a_i | input | 2 | Quadrature phase A, bit 0 low channel, bit 1 high channel |
| quad_b_i | input | 2 | Quadrature phase B, bit 0 low channel, bit 1 high channel |
| cnt_lo_o | output | 16 | Low channel count |
| cnt_hi_o | output | 16 | High channel count |
| cnt_cat_o | output | 32 | Registered {high, low} snapshot |

## Verification
Three pairs of events can fall on the same edge: a software load and a counting step on the same channel, a load of the low count while it is about to wrap, and a load of the high count while a carry arrives from below. The bench provokes these collisions directly. It drives a tick into a low count sitting at 0xFFFF in the same cycle as a load of either half, then checks that the load wins and that the high half moves only when the low half wrapped by counting. Random traffic biases loads toward 0xFFFF and 0x0000, so more collisions occur, and a cycle-exact reference model judges every edge.

// File: rtl/cascade_ctr_pkg.sv
`timescale 1ns/1ps
package cascade_ctr_pkg;

   localparam int SEL_W = 3;
   localparam logic [SEL_W-1:0] SEL_CASCADE = 3'b111;

   // Configuration word: bit 4 run, bit 3 quadrature mode, bits 2:0 select
   typedef struct packed {
      logic             run;
      logic             quad;
      logic [SEL_W-1:0] sel;
   } chan_cfg_t;

   localparam int CFG_W = $bits(chan_cfg_t);

   localparam logic [1:0] ADR_CFG_LO = 2'd0;
   localparam logic [1:0] ADR_CFG_HI = 2'd1;
   localparam logic [1:0] ADR_CNT_LO = 2'd2;
   localparam logic [1:0] ADR_CNT_HI = 2'd3;

endpackage

// File: rtl/cascade_ctr_sync.sv
`timescale 1ns/1ps
module cascade_ctr_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cascade_ctr_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cascade_ctr_quad.sv
`timescale 1ns/1ps
module cascade_ctr_quad #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic a_i,
   input  logic b_i,
   output logic up_o,
   output logic dn_o
);

   logic [1:0] cur_ab;
   logic [1:0] prv_q;

   cascade_ctr_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({a_i, b_i}),
      .q_o   (cur_ab)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) prv_q <= '0;
      else        prv_q <= cur_ab;
   end

   // 4x decode; {A,B} forward order 00 -> 10 -> 11 -> 01 -> 00
   always_comb begin
      up_o = 1'b0;
      dn_o = 1'b0;
      unique case ({prv_q, cur_ab})
         4'b0010, 4'b1011, 4'b1101, 4'b0100: up_o = 1'b1;
         4'b0001, 4'b0111, 4'b1110, 4'b1000: dn_o = 1'b1;
         default: ;
      endcase
   end

   // R5: a decoded step always follows a single-bit change of the pair
   p_quad_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_o || dn_o) |-> ($countones(prv_q ^ cur_ab) == 1))
      else $error("quad step decoded on a non-single change");

endmodule

// File: rtl/cascade_ctr_chan.sv
`timescale 1ns/1ps
module cascade_ctr_chan
   import cascade_ctr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int N_TICKS     = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_CASCADE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  chan_cfg_t          cfg_i,
   input  logic [N_TICKS-1:0] tick_i,
   input  logic               qa_i,
   input  logic               qb_i,
   input  logic               casc_up_i,
   input  logic               casc_dn_i,
   input  logic               ld_i,
   input  logic [CNT_W-1:0]   ld_val_i,
   output logic [CNT_W-1:0]   cnt_o,
   output logic               wrap_up_o,
   output logic               wrap_dn_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (N_TICKS > (1 << SEL_W) - 1) begin : g_bad_ticks
      $error("cascade_ctr_chan: N_TICKS collides with the cascade code");
   end

   logic             q_up, q_dn;
   logic             tick_hit;
   logic             casc_sel;
   logic             up_ev, dn_ev;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   cascade_ctr_quad #(.SYNC_STAGES(SYNC_STAGES)) u_quad (
      .clk   (clk),
      .rst_n (rst_n),
      .a_i   (qa_i),
      .b_i   (qb_i),
      .up_o  (q_up),
      .dn_o  (q_dn)
   );

   always_comb begin
      tick_hit = 1'b0;
      for (int k = 0; k < N_TICKS; k++) begin
         if (cfg_i.sel == SEL_W'(k)) tick_hit = tick_i[k];
      end
   end

   if (HAS_CASCADE) begin : g_casc
      assign casc_sel = (cfg_i.sel == SEL_CASCADE);
   end else begin : g_nocasc
      assign casc_sel = 1'b0;
   end

   assign up_ev = cfg_i.run & (cfg_i.quad ? q_up : (casc_sel ? casc_up_i : tick_hit));
   assign dn_ev = cfg_i.run & (cfg_i.quad ? q_dn : (casc_sel & casc_dn_i));

   always_comb begin
      cnt_d     = cnt_q;
      wrap_up_o = 1'b0;
      wrap_dn_o = 1'b0;
      if (ld_i) begin
         cnt_d = ld_val_i;
      end else if (up_ev) begin
         cnt_d     = cnt_q + ONE;
         wrap_up_o = &cnt_q;
      end else if (dn_ev) begin
         cnt_d     = cnt_q - ONE;
         wrap_dn_o = ~|cnt_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.run && !ld_i) |=> $stable(cnt_q))
      else $error("stopped channel moved");

   p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (cnt_q == $past(ld_val_i)))
      else $error("load not taken");

   p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE)
                 || (cnt_q == $past(cnt_q) - ONE)))
      else $error("count jumped by more than one");

endmodule

// File: rtl/cascade_ctr_pair.sv
`timescale 1ns/1ps
module cascade_ctr_pair
   import cascade_ctr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int N_TICKS     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [1:0]           wr_addr_i,
   input  logic [CNT_W-1:0]     wr_data_i,
   input  logic [N_TICKS-1:0]   tick_i,
   input  logic [1:0]           quad_a_i,
   input  logic [1:0]           quad_b_i,
   output logic [CNT_W-1:0]     cnt_lo_o,
   output logic [CNT_W-1:0]     cnt_hi_o,
   output logic [2*CNT_W-1:0]   cnt_cat_o
);

   localparam int CAT_W = 2 * CNT_W;
   localparam int N_CH  = 2;

   if (CNT_W < CFG_W) begin : g_bad_width
      $error("cascade_ctr_pair: CNT_W narrower than the configuration word");
   end

   chan_cfg_t        cfg_q  [N_CH];
   logic [CNT_W-1:0] cnt    [N_CH];
   logic [N_CH-1:0]  wrap_up, wrap_dn;
   logic [N_CH-1:0]  ld;
   logic [CAT_W-1:0] cat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q[0] <= '0;
         cfg_q[1] <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == ADR_CFG_LO) cfg_q[0] <= chan_cfg_t'(wr_data_i[CFG_W-1:0]);
         if (wr_addr_i == ADR_CFG_HI) cfg_q[1] <= chan_cfg_t'(wr_data_i[CFG_W-1:0]);
      end
   end

   assign ld[0] = wr_en_i && (wr_addr_i == ADR_CNT_LO);
   assign ld[1] = wr_en_i && (wr_addr_i == ADR_CNT_HI);

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      cascade_ctr_chan #(
         .CNT_W       (CNT_W),
         .N_TICKS     (N_TICKS),
         .SYNC_STAGES (SYNC_STAGES),
         .HAS_CASCADE (c == 1)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_i     (cfg_q[c]),
         .tick_i    (tick_i),
         .qa_i      (quad_a_i[c]),
         .qb_i      (quad_b_i[c]),
         .casc_up_i ((c == 1) ? wrap_up[0] : 1'b0),
         .casc_dn_i ((c == 1) ? wrap_dn[0] : 1'b0),
         .ld_i      (ld[c]),
         .ld_val_i  (wr_data_i),
         .cnt_o     (cnt[c]),
         .wrap_up_o (wrap_up[c]),
         .wrap_dn_o (wrap_dn[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cat_q <= '0;
      else        cat_q <= {cnt[1], cnt[0]};
   end

   assign cnt_lo_o  = cnt[0];
   assign cnt_hi_o  = cnt[1];
   assign cnt_cat_o = cat_q;

   logic hi_cascaded;
   assign hi_cascaded = cfg_q[1].run && !cfg_q[1].quad && (cfg_q[1].sel == SEL_CASCADE);

   p_carry_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cascaded && wrap_up[0] && !ld[1]) |=> (cnt[1] == $past(cnt[1]) + CNT_W'(1)))
      else $error("carry not applied to high half");

   p_borrow_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cascaded && wrap_dn[0] && !ld[1]) |=> (cnt[1] == $past(cnt[1]) - CNT_W'(1)))
      else $error("borrow not applied to high half");

   p_no_borrow_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[0].quad |-> !wrap_dn[0])
      else $error("low channel borrowed outside quadrature mode");

   p_lo_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q[0].quad && (cfg_q[0].sel == SEL_CASCADE) && !ld[0]) |=> $stable(cnt[0]))
      else $error("low channel counted on reserved code");

   p_hi_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_up[1] |=> (cnt[1] == '0))
      else $error("high wrap up did not land on zero");

   p_hi_wrap_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_dn[1] |=> (cnt[1] == '1))
      else $error("high wrap down did not land on all ones");

   p_snapshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (cat_q == $past({cnt[1], cnt[0]})))
      else $error("snapshot halves not from one edge");

endmodule

// File: tb/cascade_ctr_pair_bench.sv
`timescale 1ns/1ps
module cascade_ctr_pair_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  tick = '0;
   logic [1:0]  qa = '0, qb = '0;
   logic [15:0] cnt_lo, cnt_hi;
   logic [31:0] cnt_cat;

   int n_chk = 0, n_fail = 0, n_cyc = 0;

   always #2.5 clk = ~clk;

   cascade_ctr_pair u_cascade_ctr_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .tick_i    (tick),
      .quad_a_i  (qa),
      .quad_b_i  (qb),
      .cnt_lo_o  (cnt_lo),
      .cnt_hi_o  (cnt_hi),
      .cnt_cat_o (cnt_cat)
   );

   // reference model state
   logic [15:0] m_lo = '0, m_hi = '0;
   logic [31:0] m_cat = '0;
   logic [4:0]  m_cfg [2] = '{5'd0, 5'd0};
   logic [1:0]  qh1 [2] = '{2'b00, 2'b00};
   logic [1:0]  qh2 [2] = '{2'b00, 2'b00};
   logic [1:0]  qh3 [2] = '{2'b00, 2'b00};
   int          qpos [2] = '{0, 0};

   function automatic int qdir(logic [1:0] prv, logic [1:0] cur);
      logic [1:0] fwd;
      logic [1:0] bwd;
      if (prv == cur) return 0;
      case (prv)
         2'b00: begin fwd = 2'b10; bwd = 2'b01; end
         2'b10: begin fwd = 2'b11; bwd = 2'b00; end
         2'b11: begin fwd = 2'b01; bwd = 2'b10; end
         default: begin fwd = 2'b00; bwd = 2'b11; end
      endcase
      if (cur == fwd) return 1;
      if (cur == bwd) return -1;
      return 0;
   endfunction

   function automatic int tick_step(logic [4:0] cfg, logic [3:0] t);
      if (cfg[2:0] < 3'd4) return t[cfg[2:0]] ? 1 : 0;
      return 0;
   endfunction

   function automatic logic [1:0] gray(int p);
      case (p & 3)
         0: return 2'b00;
         1: return 2'b10;
         2: return 2'b11;
         default: return 2'b01;
      endcase
   endfunction

   task automatic model_edge();
      int  lo_s, hi_s;
      bit  ovf, udf;
      bit  ld_lo, ld_hi;
      ld_lo = wr_en && (wr_addr == 2'd2);
      ld_hi = wr_en && (wr_addr == 2'd3);
      lo_s = 0;
      if (m_cfg[0][4]) lo_s = m_cfg[0][3] ? qdir(qh3[0], qh2[0]) : tick_step(m_cfg[0], tick);
      ovf = !ld_lo && lo_s == 1 && m_lo == 16'hFFFF;
      udf = !ld_lo && lo_s == -1 && m_lo == 16'h0000;
      hi_s = 0;
      if (m_cfg[1][4]) begin
         if (m_cfg[1][3]) hi_s = qdir(qh3[1], qh2[1]);
         else if (m_cfg[1][2:0] == 3'b111) hi_s = ovf ? 1 : (udf ? -1 : 0);
         else hi_s = tick_step(m_cfg[1], tick);
      end
      m_cat = {m_hi, m_lo};
      if (ld_lo) m_lo = wr_data; else m_lo = m_lo + 16'(lo_s);
      if (ld_hi) m_hi = wr_data; else m_hi = m_hi + 16'(hi_s);
      if (wr_en && wr_addr == 2'd0) m_cfg[0] = wr_data[4:0];
      if (wr_en && wr_addr == 2'd1) m_cfg[1] = wr_data[4:0];
      for (int c = 0; c < 2; c++) begin
         qh3[c] = qh2[c];
         qh2[c] = qh1[c];
         qh1[c] = {qa[c], qb[c]};
      end
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
      chk("R2 model lo", {16'h0, cnt_lo}, {16'h0, m_lo});
      chk("R3 model hi", {16'h0, cnt_hi}, {16'h0, m_hi});
      chk("R9 model snapshot", cnt_cat, m_cat);
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic cfg(logic [1:0] a, bit run, bit quad, logic [2:0] sel);
      wr(a, {11'h0, run, quad, sel});
   endtask

   task automatic pulse(logic [3:0] t);
      tick = t;
      cyc();
      tick = '0;
   endtask

   task automatic qstep(int c, int d);
      logic [1:0] g;
      qpos[c] = qpos[c] + d;
      g = gray(qpos[c]);
      qa[c] = g[1];
      qb[c] = g[0];
      repeat (4) cyc();
   endtask

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<=150000", n_cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset lo", {16'h0, cnt_lo}, 32'h0);
      chk("R1 reset hi", {16'h0, cnt_hi}, 32'h0);
      chk("R1 reset snapshot", cnt_cat, 32'h0);
      rst_n = 1'b1;
      pulse(4'hF);
      chk("R1 idle after reset", {16'h0, cnt_lo}, 32'h0);

      // R2 tick selection
      cfg(2'd0, 1, 0, 3'd1);
      repeat (3) pulse(4'b0010);
      repeat (2) pulse(4'b1101);
      chk("R2 select tick 1", {16'h0, cnt_lo}, 32'd3);
      cfg(2'd0, 1, 0, 3'd5);
      pulse(4'hF);
      chk("R2 code 5 idle", {16'h0, cnt_lo}, 32'd3);
      cfg(2'd0, 1, 0, 3'd7);
      pulse(4'hF);
      chk("R2 low code 7 reserved", {16'h0, cnt_lo}, 32'd3);

      // R10 upper data bits ignored in configuration write
      wr(2'd0, 16'hFFE1);
      pulse(4'b0010);
      chk("R10 cfg high bits ignored", {16'h0, cnt_lo}, 32'd3);

      // R3 carry
      wr(2'd2, 16'hFFFE);
      wr(2'd3, 16'h1234);
      cfg(2'd1, 1, 0, 3'd7);
      cfg(2'd0, 1, 0, 3'd0);
      pulse(4'b0001);
      chk("R3 before wrap", {cnt_hi, cnt_lo}, 32'h1234FFFF);
      pulse(4'b0001);
      chk("R3 carry same edge", {cnt_hi, cnt_lo}, 32'h12350000);

      // R8 collisions
      wr(2'd2, 16'hFFFF);
      wr_en = 1; wr_addr = 2'd2; wr_data = 16'h0005; tick = 4'b0001;
      cyc();
      wr_en = 0; tick = '0;
      chk("R8 low load beats tick, no carry", {cnt_hi, cnt_lo}, 32'h12350005);
      wr(2'd2, 16'hFFFF);
      wr_en = 1; wr_addr = 2'd3; wr_data = 16'hAAAA; tick = 4'b0001;
      cyc();
      wr_en = 0; tick = '0;
      chk("R8 high load beats carry", {cnt_hi, cnt_lo}, 32'hAAAA0000);

      // R9 snapshot lag
      wr(2'd3, 16'h5555);
      chk("R9 snapshot still old", {16'h0, cnt_cat[31:16]}, 32'hAAAA);
      cyc();
      chk("R9 snapshot updated", {16'h0, cnt_cat[31:16]}, 32'h5555);
      wr(2'd3, 16'hAAAA);

      // R4 / R5 quadrature on low channel
      cfg(2'd0, 1, 1, 3'd0);
      wr(2'd2, 16'h0001);
      qstep(0, -1);
      chk("R5 B leads counts down", {16'h0, cnt_lo}, 32'h0);
      qstep(0, -1);
      chk("R4 borrow same edge", {cnt_hi, cnt_lo}, 32'hAAA9FFFF);
      repeat (3) qstep(0, 1);
      chk("R5 A leads counts up with carry", {cnt_hi, cnt_lo}, 32'hAAAA0002);
      qstep(0, 2);
      chk("R5 double change ignored", {16'h0, cnt_lo}, 32'h2);

      // R6 high in quadrature mode
      cfg(2'd1, 1, 1, 3'd7);
      wr(2'd2, 16'hFFFF);
      qstep(0, 1);
      chk("R6 carry ignored in quad mode", {cnt_hi, cnt_lo}, 32'hAAAA0000);
      pulse(4'hF);
      chk("R6 ticks ignored in quad mode", {16'h0, cnt_hi}, 32'hAAAA);
      qstep(1, 1);
      chk("R6 own quad up", {16'h0, cnt_hi}, 32'hAAAB);
      qstep(1, -1);
      chk("R6 own quad down", {16'h0, cnt_hi}, 32'hAAAA);

      // R7 run bits
      cfg(2'd1, 0, 0, 3'd7);
      cfg(2'd0, 1, 0, 3'd0);
      wr(2'd2, 16'hFFFF);
      pulse(4'b0001);
      chk("R7 stopped high ignores carry", {cnt_hi, cnt_lo}, 32'hAAAA0000);
      cfg(2'd0, 0, 0, 3'd0);
      pulse(4'hF);
      qstep(0, 1);
      chk("R7 stopped low holds", {16'h0, cnt_lo}, 32'h0);

      // random traffic
      for (int it = 0; it < 4000; it++) begin
         tick = 4'($urandom);
         wr_en = ($urandom % 12) == 0;
         wr_addr = 2'($urandom);
         case ($urandom % 5)
            0: wr_data = 16'hFFFF;
            1: wr_data = 16'h0000;
            2: wr_data = 16'hFFFE;
            3: wr_data = 16'h0001;
            default: wr_data = 16'($urandom);
         endcase
         if (wr_en && wr_addr < 2'd2 && ($urandom % 4) != 0) wr_data[4] = 1'b1;
         for (int c = 0; c < 2; c++) begin
            int r;
            logic [1:0] g;
            r = $urandom % 40;
            if (r < 8) qpos[c] = qpos[c] + 1;
            else if (r < 14) qpos[c] = qpos[c] - 1;
            else if (r == 14) qpos[c] = qpos[c] + 2;
            g = gray(qpos[c]);
            qa[c] = g[1];
            qb[c] = g[0];
         end
         cyc();
      end
      wr_en = 0; tick = '0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule